// File: doc/BRIEF.md
# Parallel Degree Switch Controller

This controller moves one software task between sequential execution and a chosen number of parallel worker instances while the system runs. An external trigger supplies the wanted degree. The controller checks it against the number of worker instances built into the system. For growth, it asks a binding-control agent for the extra processors. It then starts a reroute of the processor-task network and waits for the reroute to finish. Finally, it writes the outcome into a reserved mailbox slot, where the coordinating task reads it before each work item.

When the degree is reduced, the controller deactivates the surplus workers first and then reroutes. After that, it hands the processors back and drops their clock enables. A request that cannot be met is answered in the mailbox with a rejection code, and the running mode stays as it was. A request that arrives while a change is in progress waits in a one-entry slot. A parameter chooses whether a later request replaces the waiting one or is dropped.

Top module: `invade_ctrl`

## Requirements
- R1: After reset, no worker is active or clocked (`task_act` and `clk_en` are all zero), and `alloc_req`, `route_start`, `rel_req` and `mb_we` are all low.
- R2: A requested degree above `N_WORKERS` is rejected. The controller raises no `alloc_req` and no `route_start`, and it writes the reject code: bit MB_W-1 set, the requested degree in bits DEG_W-1:0, all other bits zero.
- R3: When the target worker count is above the current one, `alloc_req` rises with `alloc_num` equal to the difference. It stays high until `alloc_grant` or `alloc_deny` is seen.
- R4: After `alloc_deny`, the controller writes the reject code of R2 with the requested degree. `task_act`, `clk_en` and the current mode stay unchanged, and no reroute starts.
- R5: After `alloc_grant`, `clk_en` widens to the target in the next cycle and `route_start` pulses in that same cycle. `task_act` widens only in the cycle after `route_done` is sampled.
- R6: The mailbox is written for exactly one cycle per handled request, always at address `MB_SLOT`. The write comes only after the reroute finishes. An accepted change is written as bit MB_W-1 clear with the worker count in the low bits.
- R7: On a reduction, `task_act` narrows to the target in the cycle after the request is taken, and `route_start` pulses. After `route_done`, `clk_en` narrows and `rel_req` pulses once with `rel_num` equal to the number of workers released.
- R8: A requested degree of 0 or 1 selects sequential mode: the target worker count is 0, and any active workers are released as in R7.
- R9: A request whose target equals the current worker count is accepted and published without any allocation or reroute.
- R10: A request arriving while a change is in progress is held and handled after the change completes. With `KEEP_NEWEST`=1, a later arrival replaces the held one, and the replaced request is never published.
- R11: The controller waits for `route_done` as long as needed. A reroute longer than `ROUTE_LIMIT` cycles is flagged as a fault.
- R12: `task_act` and `clk_en` are thermometer masks in which worker i is set exactly when i is below the count. `task_act` is never set for a worker whose `clk_en` is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_valid | input | 1 | External degree request strobe |
| trig_degree | input | DEG_W | Requested parallel degree |
| alloc_req | output | 1 | Request for extra processors |
| alloc_num | output | CNT_W | Number of processors requested |
| alloc_grant | input | 1 | Allocation succeeded |
| alloc_deny | input | 1 | Not enough free processors |
| rel_req | output | 1 | Release pulse |
| rel_num | output | CNT_W | Number of processors released |
| route_start | output | 1 | Start pulse for network reroute and task activation |
| route_done | input | 1 | Reroute finished |
| task_act | output | N_WORKERS | Worker activation mask |
| clk_en | output | N_WORKERS | Worker processor clock enables |
| mb_we | output | 1 | Mailbox write strobe |
| mb_addr | output | SLOT_W | Reserved mailbox slot address |
| mb_data | output | MB_W | Published degree or reject code |

## Verification
The hardest state to reach from the ports is a second and a third request arriving while a reroute is still pending. They must arrive after one has already been accepted, and the replaced one must leave no trace. The bench makes a reroute window of several cycles with a delayed `route_done` response and strobes two further requests inside it. It then checks that exactly two mailbox writes follow, in order, and that the processor release matches the final degree. A sweep over every starting mode and every encodable degree covers the grant, deny, no-change and reduction paths against a modeled pool of free processors.

// File: rtl/invade_pkg.sv
package invade_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ALLOC = 2'd1,
      ST_ROUTE = 2'd2,
      ST_PUB   = 2'd3
   } inv_state_e;
endpackage

// File: rtl/inv_thermo.sv
module inv_thermo #(
   parameter int N_WORKERS = 4,
   parameter int CNT_W     = 3
) (
   input  logic [CNT_W-1:0]     cnt,
   output logic [N_WORKERS-1:0] mask
);
   for (genvar i = 0; i < N_WORKERS; i++) begin : g_bit
      assign mask[i] = (int'(cnt) > i);
   end
endmodule

// File: rtl/inv_pend_slot.sv
module inv_pend_slot #(
   parameter int DEG_W       = 3,
   parameter bit KEEP_NEWEST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [DEG_W-1:0] ld_deg,
   input  logic             take,
   output logic             valid,
   output logic [DEG_W-1:0] deg
);
   logic accept;

   if (KEEP_NEWEST) begin : g_newest
      assign accept = load;
   end else begin : g_oldest
      assign accept = load && (!valid || take);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= 1'b0;
         deg   <= '0;
      end else if (accept) begin
         valid <= 1'b1;
         deg   <= ld_deg;
      end else if (take) begin
         valid <= 1'b0;
      end
   end
endmodule

// File: rtl/invade_ctrl.sv
module invade_ctrl
   import invade_pkg::*;
#(
   parameter int N_WORKERS   = 4,
   parameter int MB_W        = 8,
   parameter int SLOT_W      = 4,
   parameter int MB_SLOT     = 15,
   parameter bit KEEP_NEWEST = 1'b1,
   parameter int ROUTE_LIMIT = 155,
   localparam int DEG_W      = $clog2(N_WORKERS + 2),
   localparam int CNT_W      = $clog2(N_WORKERS + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 trig_valid,
   input  logic [DEG_W-1:0]     trig_degree,
   output logic                 alloc_req,
   output logic [CNT_W-1:0]     alloc_num,
   input  logic                 alloc_grant,
   input  logic                 alloc_deny,
   output logic                 rel_req,
   output logic [CNT_W-1:0]     rel_num,
   output logic                 route_start,
   input  logic                 route_done,
   output logic [N_WORKERS-1:0] task_act,
   output logic [N_WORKERS-1:0] clk_en,
   output logic                 mb_we,
   output logic [SLOT_W-1:0]    mb_addr,
   output logic [MB_W-1:0]      mb_data
);
   if (N_WORKERS < 1) begin : g_chk_nw
      $error("N_WORKERS must be at least 1");
   end
   if (MB_W < DEG_W + 1) begin : g_chk_mbw
      $error("MB_W too narrow for degree plus reject flag");
   end
   if (MB_SLOT >= (1 << SLOT_W)) begin : g_chk_slot
      $error("MB_SLOT does not fit SLOT_W");
   end
   if (ROUTE_LIMIT < 1) begin : g_chk_lim
      $error("ROUTE_LIMIT must be positive");
   end

   inv_state_e         state_q;
   logic [CNT_W-1:0]   cur_q, tgt_q, act_cnt_q, en_cnt_q, reln_q;
   logic [DEG_W-1:0]   req_q;
   logic               rej_q, rs_q, rel_q;

   logic               busy, pend_v, sel_valid, over;
   logic [DEG_W-1:0]   pend_d, sel_deg;
   logic [CNT_W-1:0]   want;

   assign busy      = (state_q != ST_IDLE);
   assign sel_valid = !busy && (pend_v || trig_valid);
   assign sel_deg   = pend_v ? pend_d : trig_degree;
   assign over      = (int'(sel_deg) > N_WORKERS);
   assign want      = (sel_deg <= DEG_W'(1)) ? '0 : CNT_W'(sel_deg);

   inv_pend_slot #(.DEG_W(DEG_W), .KEEP_NEWEST(KEEP_NEWEST)) u_pend (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (trig_valid && (busy || pend_v)),
      .ld_deg (trig_degree),
      .take   (!busy && pend_v),
      .valid  (pend_v),
      .deg    (pend_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         cur_q     <= '0;
         tgt_q     <= '0;
         act_cnt_q <= '0;
         en_cnt_q  <= '0;
         reln_q    <= '0;
         req_q     <= '0;
         rej_q     <= 1'b0;
         rs_q      <= 1'b0;
         rel_q     <= 1'b0;
      end else begin
         rs_q  <= 1'b0;
         rel_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (sel_valid) begin
                  req_q <= sel_deg;
                  if (over) begin
                     rej_q   <= 1'b1;
                     state_q <= ST_PUB;
                  end else begin
                     rej_q <= 1'b0;
                     tgt_q <= want;
                     if (want > cur_q) begin
                        state_q <= ST_ALLOC;
                     end else if (want < cur_q) begin
                        act_cnt_q <= want;
                        rs_q      <= 1'b1;
                        state_q   <= ST_ROUTE;
                     end else begin
                        state_q <= ST_PUB;
                     end
                  end
               end
            end
            ST_ALLOC: begin
               if (alloc_grant) begin
                  en_cnt_q <= tgt_q;
                  rs_q     <= 1'b1;
                  state_q  <= ST_ROUTE;
               end else if (alloc_deny) begin
                  rej_q   <= 1'b1;
                  state_q <= ST_PUB;
               end
            end
            ST_ROUTE: begin
               if (route_done) begin
                  act_cnt_q <= tgt_q;
                  if (tgt_q < cur_q) begin
                     en_cnt_q <= tgt_q;
                     rel_q    <= 1'b1;
                     reln_q   <= cur_q - tgt_q;
                  end
                  cur_q   <= tgt_q;
                  state_q <= ST_PUB;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   inv_thermo #(.N_WORKERS(N_WORKERS), .CNT_W(CNT_W)) u_act_mask (
      .cnt  (act_cnt_q),
      .mask (task_act)
   );
   inv_thermo #(.N_WORKERS(N_WORKERS), .CNT_W(CNT_W)) u_en_mask (
      .cnt  (en_cnt_q),
      .mask (clk_en)
   );

   assign alloc_req   = (state_q == ST_ALLOC);
   assign alloc_num   = alloc_req ? (tgt_q - cur_q) : '0;
   assign route_start = rs_q;
   assign rel_req     = rel_q;
   assign rel_num     = reln_q;
   assign mb_we       = (state_q == ST_PUB);
   assign mb_addr     = SLOT_W'(MB_SLOT);

   always_comb begin
      mb_data           = '0;
      mb_data[MB_W-1]   = rej_q;
      mb_data[DEG_W-1:0] = rej_q ? req_q : DEG_W'(tgt_q);
   end
endmodule

// File: rtl/invade_ctrl_chk.sv
module invade_ctrl_chk #(
   parameter int N_WORKERS   = 4,
   parameter int MB_W        = 8,
   parameter int SLOT_W      = 4,
   parameter int MB_SLOT     = 15,
   parameter int ROUTE_LIMIT = 155,
   localparam int DEG_W      = $clog2(N_WORKERS + 2)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 alloc_req,
   input logic                 alloc_grant,
   input logic                 alloc_deny,
   input logic                 route_start,
   input logic                 route_done,
   input logic [N_WORKERS-1:0] task_act,
   input logic [N_WORKERS-1:0] clk_en,
   input logic                 mb_we,
   input logic [SLOT_W-1:0]    mb_addr,
   input logic [MB_W-1:0]      mb_data
);
   logic [15:0] wait_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                wait_cnt <= '0;
      else if (route_start)      wait_cnt <= 16'd1;
      else if (route_done)       wait_cnt <= '0;
      else if (wait_cnt != '0)   wait_cnt <= wait_cnt + 16'd1;
   end

   assert_route_limit_R11: assert property (@(posedge clk) disable iff (!rst_n)
      int'(wait_cnt) <= ROUTE_LIMIT);

   assert_act_in_en_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (task_act & ~clk_en) == '0);

   assert_thermo_en_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en & (clk_en + N_WORKERS'(1))) == '0);

   assert_alloc_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_req && !alloc_grant && !alloc_deny |=> alloc_req);

   assert_grant_route_R5: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_req && alloc_grant |=> route_start);

   assert_mb_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mb_we |=> !mb_we);

   assert_mb_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mb_we |-> mb_addr == SLOT_W'(MB_SLOT));

   assert_reject_keeps_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mb_we && mb_data[MB_W-1] |-> $stable(task_act) && $stable(clk_en));

   assert_worker_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mb_we && !mb_data[MB_W-1] |-> int'(mb_data[DEG_W-1:0]) <= N_WORKERS);
endmodule

bind invade_ctrl invade_ctrl_chk #(
   .N_WORKERS   (N_WORKERS),
   .MB_W        (MB_W),
   .SLOT_W      (SLOT_W),
   .MB_SLOT     (MB_SLOT),
   .ROUTE_LIMIT (ROUTE_LIMIT)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .alloc_req   (alloc_req),
   .alloc_grant (alloc_grant),
   .alloc_deny  (alloc_deny),
   .route_start (route_start),
   .route_done  (route_done),
   .task_act    (task_act),
   .clk_en      (clk_en),
   .mb_we       (mb_we),
   .mb_addr     (mb_addr),
   .mb_data     (mb_data)
);

// File: tb/sim_invade_ctrl.sv
`timescale 1ns/1ps
module sim_invade_ctrl;
   localparam int NW    = 4;
   localparam int DEG_W = $clog2(NW + 2);
   localparam int CNT_W = $clog2(NW + 1);
   localparam int MB_W  = 8;
   localparam int SLOT  = 15;
   localparam int POOL  = 3;

   logic clk = 1'b0, rst_n = 1'b0;
   logic trig_valid = 1'b0;
   logic [DEG_W-1:0] trig_degree = '0;
   logic alloc_grant = 1'b0, alloc_deny = 1'b0, route_done = 1'b0;
   logic alloc_req, rel_req, route_start, mb_we;
   logic [CNT_W-1:0] alloc_num, rel_num;
   logic [NW-1:0] task_act, clk_en;
   logic [3:0] mb_addr;
   logic [MB_W-1:0] mb_data;

   always #10 clk = ~clk;

   invade_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid), .trig_degree(trig_degree),
      .alloc_req(alloc_req), .alloc_num(alloc_num), .alloc_grant(alloc_grant),
      .alloc_deny(alloc_deny), .rel_req(rel_req), .rel_num(rel_num),
      .route_start(route_start), .route_done(route_done), .task_act(task_act),
      .clk_en(clk_en), .mb_we(mb_we), .mb_addr(mb_addr), .mb_data(mb_data)
   );

   int total = 0, bad = 0;
   int free_p = POOL, n_alloc = 0, n_route = 0, rel_sum = 0, mb_cnt = 0;
   int rt_cnt = 0, route_delay = 2, exp_alloc = 0, mode = 0;
   logic [MB_W-1:0] mb_last = '0, mb_prev = '0;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int mask(input int m);
      return (1 << m) - 1;
   endfunction

   // binding-control and routing agent model
   always @(negedge clk) begin
      if (rst_n) begin
         alloc_grant <= 1'b0;
         alloc_deny  <= 1'b0;
         route_done  <= 1'b0;
         if (alloc_req && !alloc_grant && !alloc_deny) begin
            n_alloc++;
            check(int'(alloc_num) == exp_alloc, "R3 alloc_num", alloc_num, exp_alloc);
            if (int'(alloc_num) <= free_p) begin
               alloc_grant <= 1'b1;
               free_p -= int'(alloc_num);
            end else begin
               alloc_deny <= 1'b1;
            end
         end
         if (route_start) begin
            n_route++;
            rt_cnt = route_delay;
         end else if (rt_cnt > 0) begin
            rt_cnt--;
            if (rt_cnt == 0) route_done <= 1'b1;
         end
         if (rel_req) begin
            free_p  += int'(rel_num);
            rel_sum += int'(rel_num);
         end
         if (mb_we) begin
            mb_cnt++;
            mb_prev = mb_last;
            mb_last = mb_data;
            check(mb_addr == 4'(SLOT), "R6 slot", mb_addr, SLOT);
         end
      end
   end

   task automatic strobe(input int d);
      @(posedge clk); #1;
      trig_valid  = 1'b1;
      trig_degree = DEG_W'(d);
      @(posedge clk); #1;
      trig_valid  = 1'b0;
   endtask

   task automatic wait_mb(input int target);
      for (int k = 0; k < 600 && mb_cnt < target; k++) begin
         @(posedge clk); #1;
      end
      repeat (2) begin @(posedge clk); #1; end
      check(mb_cnt == target, "R6 mailbox count", mb_cnt, target);
   endtask

   task automatic go(input int d);
      int w, exp_data, a0, r0, s0, m0, exp_rel;
      bit over, grow, deny, acc;
      string tag;
      w    = (d <= 1) ? 0 : d;
      over = d > NW;
      grow = !over && w > mode;
      deny = grow && w > POOL;
      acc  = !over && !deny;
      exp_data = (over || deny) ? ((1 << (MB_W-1)) | d) : w;
      exp_rel  = (acc && w < mode) ? mode - w : 0;
      tag = over ? "R2" : deny ? "R4" : (d <= 1) ? "R8" : (w == mode) ? "R9" : grow ? "R5" : "R7";
      exp_alloc = w - mode;
      a0 = n_alloc; r0 = n_route; s0 = rel_sum; m0 = mb_cnt;
      strobe(d);
      wait_mb(m0 + 1);
      check(int'(mb_last) == exp_data, {tag, " mailbox data"}, mb_last, exp_data);
      check(n_alloc - a0 == int'(grow), {tag, " R3 alloc count"}, n_alloc - a0, int'(grow));
      check(n_route - r0 == int'(acc && w != mode), {tag, " route count"}, n_route - r0,
            int'(acc && w != mode));
      check(rel_sum - s0 == exp_rel, {tag, " R7 release"}, rel_sum - s0, exp_rel);
      if (acc) mode = w;
      check(int'(task_act) == mask(mode), {tag, " task_act"}, task_act, mask(mode));
      check(int'(clk_en) == mask(mode), {tag, " R12 clk_en"}, clk_en, mask(mode));
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      check(task_act == '0 && clk_en == '0, "R1 masks", {task_act, clk_en}, 0);
      check(!alloc_req && !route_start && !rel_req && !mb_we, "R1 strobes",
            {alloc_req, route_start, rel_req, mb_we}, 0);
      rst_n = 1'b1;
      repeat (2) begin @(posedge clk); #1; end
      check(task_act == '0 && !mb_we, "R1 idle after release", task_act, 0);

      // sweep every reachable start mode against every encodable degree
      for (int from = 0; from <= POOL; from++) begin
         for (int r = 0; r < (1 << DEG_W); r++) begin
            go(from);
            go(r);
         end
      end

      // R5 timing: clk_en widens before task_act, which waits for route_done
      go(0);
      route_delay = 8;
      exp_alloc = 2;
      strobe(2);
      for (int k = 0; k < 4; k++) begin @(posedge clk); #1; end
      check(int'(clk_en) == 3 && task_act == '0, "R5 enable before activate",
            {clk_en, task_act}, 3 << NW);
      wait_mb(mb_cnt + 1);
      mode = 2;
      check(int'(task_act) == 3, "R5 activate after done", task_act, 3);

      // R10 pending requests during a reroute, newest wins
      go(0);
      route_delay = 10;
      begin
         int m0, r0, s0;
         m0 = mb_cnt; r0 = n_route; s0 = rel_sum;
         exp_alloc = 3;
         strobe(3);
         repeat (3) begin @(posedge clk); #1; end
         strobe(2);
         strobe(0);
         wait_mb(m0 + 2);
         repeat (20) begin @(posedge clk); #1; end
         check(mb_cnt - m0 == 2, "R10 writes", mb_cnt - m0, 2);
         check(int'(mb_prev) == 3, "R10 first published", mb_prev, 3);
         check(int'(mb_last) == 0, "R10 newest published", mb_last, 0);
         check(n_route - r0 == 2, "R10 routes", n_route - r0, 2);
         check(rel_sum - s0 == 3, "R10 release", rel_sum - s0, 3);
         check(task_act == '0 && clk_en == '0, "R10 final mode", {task_act, clk_en}, 0);
         mode = 0;
      end

      // R11 long reroute still within the limit
      route_delay = 150;
      go(3);
      route_delay = 2;
      go(1);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule